// File: doc/BRIEF.md
# Reset Release Synchronizer (trailing-edge form)

This block takes one asynchronous reset input and turns it into a reset output for a single clock domain. When the input asserts, the output follows through one combinational gate. No clock edge is needed. When the input lets go, the output does not fall at once. The release first travels down a chain of plain D flip-flops clocked by the domain clock, and the output falls only when the last flip-flop has taken the deasserted level. That edge is a clean, synchronous release for every flop downstream.

The input polarity is a parameter. With an active-high input the merge gate is an OR. With an active-low input it is the NAND form, which still gives an active-high output. The chain depth is also a parameter. The default is two stages, and a deeper chain gives a longer MTBF.

The chain flip-flops have no reset or set pins. While the input is asserted, the chain fills with ones only if the clock is running. The clock therefore has to toggle for at least the chain depth while reset is held. The last stage feeds only the merge gate, and the block is meant to be kept as one instance and never copied per fanout branch.

Top module: `rst_release_sync`

## Requirements
- R1: The output goes high in the same time step that the input asserts, with no clock edge in between. This also holds before the clock has ever toggled.
- R2: With the polarity parameter at POL_HIGH, an input of 1 means reset asserted and 0 means released.
- R3: With the polarity parameter at POL_LOW, an input of 0 means reset asserted and 1 means released. The output stays active-high.
- R4: The output stays high at every clock edge for as long as the input stays asserted.
- R5: The input may be released after it has been asserted for at least STAGES clock edges. In that case the output stays high through the first STAGES-1 rising edges after release and falls on rising edge number STAGES. A metastable first stage may add one more edge on silicon.
- R6: The input may reassert while a release is still travelling down the chain. The output then does not drop at all, and the next release again takes the full STAGES edges.
- R7: The parameter STAGES sets the number of flip-flops in the chain and so sets the release latency. It must be at least 2.
- R8: Once released, the output stays low for as long as the input stays deasserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the target domain |
| rst_in | input | 1 | Asynchronous reset; polarity set by IN_POL |
| rst_out | output | 1 | Active-high reset: asserts asynchronously, releases synchronously |

## Verification
Assertion through the gate and release through the chain can meet in the same cycle. This happens when the input asserts again while a zero is still moving down the chain. The bench provokes it directly: it releases the input, lets one rising edge pass, and then reasserts the input on the following falling edge. It judges the result in two ways. First, the output must read high at every sample in that window. Second, the release that follows must take the full STAGES edges. This is checked on a two-stage active-high instance and a three-stage active-low instance side by side.

// File: rtl/rsync_pkg.sv
package rsync_pkg;
  // Polarity of the incoming asynchronous reset.
  typedef enum logic {
    POL_HIGH = 1'b0,
    POL_LOW  = 1'b1
  } rst_pol_e;
endpackage

// File: rtl/rsync_level_norm.sv
// Converts the raw reset pin into an "asserted = 1" level that feeds the chain.
module rsync_level_norm
  import rsync_pkg::*;
#(
  parameter rst_pol_e IN_POL = POL_HIGH
) (
  input  logic raw_rst,
  output logic asserted
);
  generate
    if (IN_POL == POL_LOW) begin : g_low
      assign asserted = ~raw_rst;
    end else begin : g_high
      assign asserted = raw_rst;
    end
  endgenerate
endmodule

// File: rtl/rsync_dff_chain.sv
// Shift chain of plain D flip-flops with no reset or set. While reset is held,
// it fills with ones from a running clock and then carries the release level.
module rsync_dff_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic din,
  output logic dout
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] stage_q;

  always_ff @(posedge clk) begin
    stage_q[0] <= din;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  endgenerate

  // The last stage has exactly one load: the merge gate in the top module.
  assign dout = stage_q[LAST];
endmodule

// File: rtl/rsync_out_gate.sv
// Merges the raw input with the synchronized chain tail into an active-high output.
module rsync_out_gate
  import rsync_pkg::*;
#(
  parameter rst_pol_e IN_POL = POL_HIGH
) (
  input  logic raw_rst,
  input  logic chain_tail,
  output logic rst_out
);
  generate
    if (IN_POL == POL_LOW) begin : g_nand
      // Active-low input: NAND of the pin and the inverted tail.
      assign rst_out = ~(raw_rst & ~chain_tail);
    end else begin : g_or
      assign rst_out = raw_rst | chain_tail;
    end
  endgenerate
endmodule

// File: rtl/rst_release_sync.sv
// Reset synchronizer: assertion passes through asynchronously, release goes
// through a chain of plain flip-flops. Keep this instance whole: copying it
// per fanout branch gives copies whose releases can land on different cycles.
module rst_release_sync
  import rsync_pkg::*;
#(
  parameter rst_pol_e IN_POL = POL_HIGH,
  parameter int       STAGES = 2
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_out
);
  logic asserted_lvl;
  logic tail;

  rsync_level_norm #(.IN_POL(IN_POL)) u_norm (
    .raw_rst  (rst_in),
    .asserted (asserted_lvl)
  );

  rsync_dff_chain #(.STAGES(STAGES)) u_chain (
    .clk  (clk),
    .din  (asserted_lvl),
    .dout (tail)
  );

  rsync_out_gate #(.IN_POL(IN_POL)) u_gate (
    .raw_rst    (rst_in),
    .chain_tail (tail),
    .rst_out    (rst_out)
  );
endmodule

// File: rtl/rsync_checker.sv
module rsync_checker
  import rsync_pkg::*;
#(
  parameter rst_pol_e IN_POL = POL_HIGH,
  parameter int       STAGES = 2
) (
  input logic clk,
  input logic rst_in,
  input logic rst_out
);
  localparam int CW = $clog2(STAGES + 2) + 1;

  logic in_asserted;
  assign in_asserted = (IN_POL == POL_LOW) ? !rst_in : rst_in;

  logic [CW-1:0] asserted_run = '0;
  logic [CW-1:0] released_run = '0;

  always_ff @(posedge clk) begin
    if (in_asserted) begin
      released_run <= '0;
      if (released_run != '0)
        asserted_run <= CW'(1);
      else if (asserted_run < CW'(STAGES))
        asserted_run <= asserted_run + CW'(1);
    end else if (released_run <= CW'(STAGES)) begin
      released_run <= released_run + CW'(1);
    end
  end

  // R1: an asserted input shows at the output between edges
  always @(negedge clk) begin
    if (in_asserted) assert_follow_low_R1: assert (rst_out);
  end

  // R4: an asserted input shows at the output at every edge
  always @(posedge clk) begin
    if (in_asserted) assert_hold_edge_R4: assert (rst_out);
  end

  // R5: after a full fill, no release before STAGES edges
  assert_no_early_release_R5: assert property (@(posedge clk) disable iff (in_asserted)
    (asserted_run >= CW'(STAGES) && released_run < CW'(STAGES)) |-> rst_out);

  // R5: release has happened once STAGES edges have passed
  assert_released_R5: assert property (@(posedge clk) disable iff (in_asserted)
    (released_run >= CW'(STAGES)) |-> !rst_out);

  // R8: output stays put while idle
  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (in_asserted)
    (released_run >= CW'(STAGES)) |=> $stable(rst_out));
endmodule

bind rst_release_sync rsync_checker #(.IN_POL(IN_POL), .STAGES(STAGES)) u_rsync_chk (
  .clk     (clk),
  .rst_in  (rst_in),
  .rst_out (rst_out)
);

// File: tb/rst_release_sync_test.sv
module rst_release_sync_test;
  import rsync_pkg::*;

  localparam int CLK_P = 10;
  localparam int ST_A  = 2;
  localparam int ST_B  = 3;

  logic clk = 1'b0;
  logic clk_run = 1'b0;
  logic rst_a = 1'b1;    // active-high input, unit A
  logic rst_b_n = 1'b0;  // active-low input, unit B
  logic out_a, out_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) if (clk_run) clk = ~clk;

  rst_release_sync #(.IN_POL(POL_HIGH), .STAGES(ST_A)) uut (
    .clk(clk), .rst_in(rst_a), .rst_out(out_a));

  rst_release_sync #(.IN_POL(POL_LOW), .STAGES(ST_B)) uut_b (
    .clk(clk), .rst_in(rst_b_n), .rst_out(out_b));

  function automatic int exp_latency(int stages);
    return stages;
  endfunction

  function automatic logic exp_out_during_release(int edges_seen, int stages);
    return (edges_seen < stages) ? 1'b1 : 1'b0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(bit assert_rst);
    rst_a   = assert_rst;
    rst_b_n = ~assert_rst;
  endtask

  // Hold reset for n edges; every sample must show the output high (R4)
  task automatic hold_asserted(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      check(out_a == 1'b1, "R4 R2", out_a, 1, "A high while held");
      check(out_b == 1'b1, "R4 R3", out_b, 1, "B high while held");
    end
  endtask

  // Release on a falling edge and measure edges until each output falls (R5, R7)
  task automatic release_and_measure(string tag);
    int lat_a = 0;
    int lat_b = 0;
    @(negedge clk); #1;
    drive(1'b0);
    #1;
    check(out_a == 1'b1 && out_b == 1'b1, "R5", {out_a, out_b}, 3, {tag, " no release without edge"});
    for (int k = 1; k <= ST_B + 3; k++) begin
      @(posedge clk); #1;
      if (lat_a == 0 && !out_a) lat_a = k;
      if (lat_b == 0 && !out_b) lat_b = k;
      if (k <= ST_B)
        check(out_b == exp_out_during_release(k, ST_B), "R5", out_b,
              exp_out_during_release(k, ST_B), {tag, " B per-edge"});
    end
    check(lat_a == exp_latency(ST_A), "R5 R7", lat_a, exp_latency(ST_A), {tag, " A latency"});
    check(lat_b == exp_latency(ST_B), "R5 R7", lat_b, exp_latency(ST_B), {tag, " B latency"});
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      check(out_a == 1'b0 && out_b == 1'b0, "R8", {out_a, out_b}, 0, "outputs low while idle");
    end
  endtask

  // Assert between edges; output must rise before any edge (R1)
  task automatic assert_between_edges();
    @(negedge clk); #1;
    drive(1'b1);
    #1;
    check(out_a == 1'b1, "R1 R2", out_a, 1, "A rises with no edge");
    check(out_b == 1'b1, "R1 R3", out_b, 1, "B rises with no edge");
  endtask

  initial begin
    void'($urandom(32'd24680));
    drive(1'b1);
    #1;
    // R1: asserted before the clock ever runs, chain still unknown
    check(out_a == 1'b1, "R1", out_a, 1, "A high before any clock");
    check(out_b == 1'b1, "R1", out_b, 1, "B high before any clock");
    #(CLK_P);
    clk_run = 1'b1;
    hold_asserted(ST_B + 2);
    release_and_measure("first");
    idle(4);

    // R6: reassert one edge into the release
    assert_between_edges();
    hold_asserted(ST_B + 1);
    @(negedge clk); #1;
    drive(1'b0);
    @(posedge clk); #1;
    check(out_a == 1'b1 && out_b == 1'b1, "R6", {out_a, out_b}, 3, "high one edge into release");
    @(negedge clk); #1;
    drive(1'b1);
    #1;
    check(out_a == 1'b1 && out_b == 1'b1, "R6", {out_a, out_b}, 3, "no drop at reassertion");
    hold_asserted(ST_B + 1);
    release_and_measure("R6 restart");
    idle(3);

    // Random hold and idle lengths
    for (int it = 0; it < 25; it++) begin
      int hold_n = ST_B + int'($urandom % 9);
      int idle_n = 1 + int'($urandom % 6);
      assert_between_edges();
      hold_asserted(hold_n);
      release_and_measure("random");
      idle(idle_n);
    end

    // R8: long idle stretch
    idle(40);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1-watchdog actual=%0d expected=%0d timeout", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule